// File: doc/BRIEF.md
# Time-Multiplexed Inter-Chip Signal Pin Sharer

This block lets a partition of an emulated design exchange more logical signals with its neighbouring chips than it has physical pins. A fast microcycle clock steps a one-hot slot sequencer through a fixed number of slots. In each slot, every output pin is driven from a source picked by a compile-time schedule. The source is a local logical signal, the value that an input pin carried in the previous slot (used to pass a signal through this chip toward a farther one), or nothing. In the same slot, every input pin may be captured into one holding register that feeds the emulated logic.

One pass through all slots forms one emulated design cycle. During the last slot, a strobe tells the emulated registers to advance. Slots in which every output entry is idle serve as local evaluation time, and the pins stay low in those slots. Several instances wired output-to-input in a chain, all sharing the same schedule, reproduce what direct wires between the partitions would deliver.

Top module: `vwire_pinmux`

## Requirements
- R1: A synchronous reset that is high at a clock edge puts the sequencer in slot 0 and clears every holding register and the internal previous-slot pin copies. While in reset, `emu_en_o` is low and, under the default schedule, all output pins are 0.
- R2: Outside reset, the sequencer moves forward one slot on every clock. Exactly one slot is active at any time. After slot NSLOT-1, the next slot is 0.
- R3: `emu_en_o` is high only during slot NSLOT-1. It therefore pulses for one clock once every NSLOT clocks.
- R4: Each output schedule entry is 8 bits. Bits [7:6] give the kind (00 idle, 01 local, 10 forward) and bits [5:0] give an index. For a local entry, the pin drives `sig_i[index]` during that slot.
- R5: An idle entry drives its pin to 0. Under the default schedule, slots 0, 3 and 6 are evaluation slots, and both pins are 0 in them.
- R6: Each input schedule entry is 8 bits. Bit 7 means capture and bits [6:0] give a holding-register index. For a capture entry, `hold_o[index]` takes the pin's value at the clock edge that ends the slot.
- R7: A holding register keeps its value through every slot that does not capture into it, including across the wrap into the next emulated cycle.
- R8: For a forward entry, the pin drives the value that input pin `index` carried during the previous slot. This gives a through-hop that costs two communication slots.
- R9: In a three-instance chain using the default schedule, the downstream instance's holds equal the following at the strobe. H0, H2, H3, H4 and H5 equal the upstream local signals L0, L2, L3, L4 and L5. H1 and H6 equal L1 and L4 of the chip two hops upstream. H7 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Microcycle clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sig_i | input | NSIG | Local logical signals to be sent, held stable during an emulated cycle |
| pin_i | input | NIPIN | Physical input pins from the upstream chip |
| pin_o | output | NOPIN | Physical output pins to the downstream chip |
| hold_o | output | NHOLD | Holding registers of received logical signals |
| emu_en_o | output | 1 | Emulated clock enable, high during the last slot |

## Verification
Output pins are combinational from the current slot, so pin values are due in the same slot that selects them. The bench samples them on the falling edge with its own slot counter, which restarts on reset. A capture lands at the rising edge that ends its slot. The chain's holds are therefore compared on the falling edge of the last slot, once every slot that captures in that cycle has ended. The retention checks sample in slot 4 and slot 0 of the next cycle, before any new capture has landed. Local signals change only on the falling edge inside the last slot, so every cycle's results depend on a single known set of inputs.

// File: rtl/vw_pkg.sv
package vw_pkg;

    localparam int ENT_W     = 8;
    localparam int DEF_NSLOT = 7;
    localparam int DEF_NPIN  = 2;

    localparam logic [1:0] KIND_IDLE  = 2'b00;
    localparam logic [1:0] KIND_LOCAL = 2'b01;
    localparam logic [1:0] KIND_FWD   = 2'b10;

    function automatic logic [ENT_W-1:0] mk_local(input int idx);
        mk_local = {KIND_LOCAL, 6'(idx)};
    endfunction

    function automatic logic [ENT_W-1:0] mk_fwd(input int idx);
        mk_fwd = {KIND_FWD, 6'(idx)};
    endfunction

    function automatic logic [ENT_W-1:0] mk_cap(input int idx);
        mk_cap = {1'b1, 7'(idx)};
    endfunction

    // Default transmit schedule: (slot, pin) entry at bit (slot*NPIN+pin)*ENT_W
    function automatic logic [DEF_NSLOT*DEF_NPIN*ENT_W-1:0] def_out_tbl();
        logic [DEF_NSLOT*DEF_NPIN*ENT_W-1:0] t;
        t = '0;
        t[(1*DEF_NPIN+0)*ENT_W +: ENT_W] = mk_local(0);
        t[(1*DEF_NPIN+1)*ENT_W +: ENT_W] = mk_local(1);
        t[(2*DEF_NPIN+0)*ENT_W +: ENT_W] = mk_fwd(1);
        t[(2*DEF_NPIN+1)*ENT_W +: ENT_W] = mk_local(2);
        t[(4*DEF_NPIN+0)*ENT_W +: ENT_W] = mk_local(3);
        t[(4*DEF_NPIN+1)*ENT_W +: ENT_W] = mk_local(4);
        t[(5*DEF_NPIN+0)*ENT_W +: ENT_W] = mk_local(5);
        t[(5*DEF_NPIN+1)*ENT_W +: ENT_W] = mk_fwd(1);
        return t;
    endfunction

    // Default receive schedule
    function automatic logic [DEF_NSLOT*DEF_NPIN*ENT_W-1:0] def_in_tbl();
        logic [DEF_NSLOT*DEF_NPIN*ENT_W-1:0] t;
        t = '0;
        t[(1*DEF_NPIN+0)*ENT_W +: ENT_W] = mk_cap(0);
        t[(2*DEF_NPIN+0)*ENT_W +: ENT_W] = mk_cap(1);
        t[(2*DEF_NPIN+1)*ENT_W +: ENT_W] = mk_cap(2);
        t[(4*DEF_NPIN+0)*ENT_W +: ENT_W] = mk_cap(3);
        t[(4*DEF_NPIN+1)*ENT_W +: ENT_W] = mk_cap(4);
        t[(5*DEF_NPIN+0)*ENT_W +: ENT_W] = mk_cap(5);
        t[(5*DEF_NPIN+1)*ENT_W +: ENT_W] = mk_cap(6);
        return t;
    endfunction

endpackage

// File: rtl/vw_slot_seq.sv
module vw_slot_seq #(
    parameter int NSLOT = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [NSLOT-1:0] slot_oh_o,
    output logic             last_o
);

    typedef struct packed {
        logic [NSLOT-1:0] oh;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.oh = {st_q.oh[NSLOT-2:0], st_q.oh[NSLOT-1]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= '0;
            st_q.oh <= NSLOT'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_oh_o = st_q.oh;
    assign last_o    = st_q.oh[NSLOT-1];

endmodule

// File: rtl/vw_tx_mux.sv
module vw_tx_mux
    import vw_pkg::*;
#(
    parameter int NSLOT = 7,
    parameter int NOPIN = 2,
    parameter int NIPIN = 2,
    parameter int NSIG  = 6,
    parameter logic [NSLOT*NOPIN*ENT_W-1:0] OUT_TBL = def_out_tbl()
) (
    input  logic [NSLOT-1:0] slot_oh_i,
    input  logic [NSIG-1:0]  sig_i,
    input  logic [NIPIN-1:0] fwd_i,
    output logic [NOPIN-1:0] pin_o
);

    for (genvar p = 0; p < NOPIN; p++) begin : g_pin
        logic pin_d;
        always_comb begin
            logic [ENT_W-1:0] ent;
            int               idx;
            pin_d = 1'b0;
            for (int s = 0; s < NSLOT; s++) begin
                ent = OUT_TBL[(s*NOPIN+p)*ENT_W +: ENT_W];
                idx = int'(ent[5:0]);
                if (slot_oh_i[s]) begin
                    if (ent[7:6] == KIND_LOCAL && idx < NSIG) begin
                        pin_d = sig_i[idx];
                    end else if (ent[7:6] == KIND_FWD && idx < NIPIN) begin
                        pin_d = fwd_i[idx];
                    end
                end
            end
        end
        assign pin_o[p] = pin_d;
    end

endmodule

// File: rtl/vw_rx_capture.sv
module vw_rx_capture
    import vw_pkg::*;
#(
    parameter int NSLOT = 7,
    parameter int NIPIN = 2,
    parameter int NHOLD = 8,
    parameter logic [NSLOT*NIPIN*ENT_W-1:0] IN_TBL = def_in_tbl()
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NSLOT-1:0] slot_oh_i,
    input  logic [NIPIN-1:0] pin_i,
    output logic [NHOLD-1:0] hold_o,
    output logic [NIPIN-1:0] prev_pin_o
);

    typedef struct packed {
        logic [NHOLD-1:0] hold;
        logic [NIPIN-1:0] prev;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        logic [ENT_W-1:0] ent;
        int               idx;
        st_d      = st_q;
        st_d.prev = pin_i;
        for (int s = 0; s < NSLOT; s++) begin
            for (int p = 0; p < NIPIN; p++) begin
                ent = IN_TBL[(s*NIPIN+p)*ENT_W +: ENT_W];
                idx = int'(ent[6:0]);
                if (slot_oh_i[s] && ent[7] && idx < NHOLD) begin
                    st_d.hold[idx] = pin_i[p];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o     = st_q.hold;
    assign prev_pin_o = st_q.prev;

endmodule

// File: rtl/vwire_pinmux.sv
module vwire_pinmux
    import vw_pkg::*;
#(
    parameter int NSIG  = 6,
    parameter int NHOLD = 8,
    parameter int NOPIN = 2,
    parameter int NIPIN = 2,
    parameter int NSLOT = 7,
    parameter logic [NSLOT*NOPIN*ENT_W-1:0] OUT_TBL = def_out_tbl(),
    parameter logic [NSLOT*NIPIN*ENT_W-1:0] IN_TBL  = def_in_tbl()
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NSIG-1:0]  sig_i,
    input  logic [NIPIN-1:0] pin_i,
    output logic [NOPIN-1:0] pin_o,
    output logic [NHOLD-1:0] hold_o,
    output logic             emu_en_o
);

    logic [NSLOT-1:0] slot_oh;
    logic [NIPIN-1:0] prev_pin;

    vw_slot_seq #(
        .NSLOT(NSLOT)
    ) seq_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .slot_oh_o(slot_oh),
        .last_o   (emu_en_o)
    );

    vw_tx_mux #(
        .NSLOT  (NSLOT),
        .NOPIN  (NOPIN),
        .NIPIN  (NIPIN),
        .NSIG   (NSIG),
        .OUT_TBL(OUT_TBL)
    ) tx_i (
        .slot_oh_i(slot_oh),
        .sig_i    (sig_i),
        .fwd_i    (prev_pin),
        .pin_o    (pin_o)
    );

    vw_rx_capture #(
        .NSLOT (NSLOT),
        .NIPIN (NIPIN),
        .NHOLD (NHOLD),
        .IN_TBL(IN_TBL)
    ) rx_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .slot_oh_i (slot_oh),
        .pin_i     (pin_i),
        .hold_o    (hold_o),
        .prev_pin_o(prev_pin)
    );

endmodule

// File: rtl/vwire_pinmux_chk.sv
module vwire_pinmux_chk #(
    parameter int NSLOT = 7,
    parameter int NHOLD = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [NSLOT-1:0] slot_oh,
    input logic             emu_en,
    input logic [NHOLD-1:0] hold
);

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (hold == '0 && slot_oh[0] && !emu_en));

    assert_single_slot_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(slot_oh) == 1);

    assert_wrap_after_strobe_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        emu_en |=> slot_oh[0]);

    assert_strobe_one_clock_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        emu_en |=> !emu_en);

endmodule

bind vwire_pinmux vwire_pinmux_chk #(
    .NSLOT(NSLOT),
    .NHOLD(NHOLD)
) chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .slot_oh(slot_oh),
    .emu_en (emu_en_o),
    .hold   (hold_o)
);

// File: tb/vwire_pinmux_tb_top.sv
module vwire_pinmux_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] sig_a = '0, sig_b = '0, sig_c = '0;
    logic [1:0] pin_a_in = '0;
    logic [1:0] pin_ab, pin_bc, pin_c_out;
    logic [7:0] hold_a, hold_b, hold_c;
    logic       en_a, en_b, en_c;

    int total = 0;
    int bad   = 0;
    int bslot = 0;
    logic [5:0] pa_prev, pb_prev;
    bit prev_ok = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) bslot <= 0;
        else     bslot <= (bslot == 6) ? 0 : bslot + 1;
    end

    vwire_pinmux dut_i (
        .clk_i(clk), .rst_i(rst), .sig_i(sig_a), .pin_i(pin_a_in),
        .pin_o(pin_ab), .hold_o(hold_a), .emu_en_o(en_a));

    vwire_pinmux chip_b_i (
        .clk_i(clk), .rst_i(rst), .sig_i(sig_b), .pin_i(pin_ab),
        .pin_o(pin_bc), .hold_o(hold_b), .emu_en_o(en_b));

    vwire_pinmux chip_c_i (
        .clk_i(clk), .rst_i(rst), .sig_i(sig_c), .pin_i(pin_bc),
        .pin_o(pin_c_out), .hold_o(hold_c), .emu_en_o(en_c));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s slot=%0d actual=%h expected=%h", req, bslot, act, exp);
        end
    endtask

    // Hold image of a chip whose upstream sends up, and whose second-upstream sends up2 (R9)
    function automatic logic [7:0] exp_hold(input logic [5:0] up, input logic [5:0] up2);
        logic [7:0] h;
        h = '0;
        h[0] = up[0];
        h[1] = up2[1];
        h[2] = up[2];
        h[3] = up[3];
        h[4] = up[4];
        h[5] = up[5];
        h[6] = up2[4];
        return h;
    endfunction

    // Pin image of chip A (its input tied to zero) per slot: R4, R5, R8
    function automatic logic [1:0] exp_pin_a(input int s, input logic [5:0] l);
        case (s)
            1:       return {l[1], l[0]};
            2:       return {l[2], 1'b0};
            4:       return {l[4], l[3]};
            5:       return {1'b0, l[5]};
            default: return 2'b00;
        endcase
    endfunction

    task automatic new_sigs(input int n);
        pa_prev = sig_a;
        pb_prev = sig_b;
        case (n)
            0:       begin sig_a = 6'h3f; sig_b = 6'h3f; end
            1:       begin sig_a = 6'h00; sig_b = 6'h00; end
            2:       begin sig_a = 6'h15; sig_b = 6'h2a; end
            3:       begin sig_a = 6'h12; sig_b = 6'h09; end
            default: begin sig_a = 6'($urandom); sig_b = 6'($urandom); end
        endcase
        sig_c = 6'($urandom);
    endtask

    task automatic step(input int i, inout int ncyc);
        chk("R3 strobe", 32'(en_a), 32'(bslot == 6));
        chk("R4/R5/R8 chip A pins", 32'(pin_ab), 32'(exp_pin_a(bslot, sig_a)));
        if (bslot == 2) chk("R8 through-hop out", 32'(pin_bc[0]), 32'(sig_a[1]));
        if (bslot == 5) chk("R8 through-hop out", 32'(pin_bc[1]), 32'(sig_a[4]));
        if (bslot == 4)
            chk("R7 mid-cycle hold", 32'(hold_c[2:0]), 32'(exp_hold(sig_b, sig_a) & 8'h07));
        if (bslot == 0 && prev_ok) begin
            chk("R7 hold across wrap B", 32'(hold_b), 32'(exp_hold(pa_prev, 6'h00)));
            chk("R7 hold across wrap C", 32'(hold_c), 32'(exp_hold(pb_prev, pa_prev)));
        end
        if (bslot == 6) begin
            chk("R6/R9 chain hold B", 32'(hold_b), 32'(exp_hold(sig_a, 6'h00)));
            chk("R6/R9 chain hold C", 32'(hold_c), 32'(exp_hold(sig_b, sig_a)));
            chk("R9 chip A holds idle", 32'(hold_a), 32'h0);
            prev_ok = 1'b1;
            new_sigs(ncyc);
            ncyc++;
        end
        if (i == 1000 && bslot == 3) begin
            rst = 1'b1;
            @(negedge clk);
            chk("R1 mid reset holds", 32'({hold_b, hold_c}), 32'h0);
            chk("R1 mid reset strobe", 32'(en_a), 32'h0);
            chk("R1 mid reset pins", 32'(pin_ab), 32'h0);
            rst = 1'b0;
            prev_ok = 1'b0;
        end
    endtask

    initial begin
        int ncyc = 0;
        void'($urandom(32'd4711));
        new_sigs(ncyc);
        ncyc++;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset holds", 32'({hold_a, hold_b, hold_c}), 32'h0);
        chk("R1 reset strobe", 32'(en_a), 32'h0);
        chk("R1 reset pins", 32'(pin_ab), 32'h0);
        rst = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            step(i, ncyc);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule